// File: doc/BRIEF.md
# Single-Beat Slave Chip-Enable Decoder

This block sits between a simple upstream request port and user logic that exposes registers or memories. The upstream side issues one single-beat transfer at a time: a one-cycle request strobe together with an address, write data, byte enables and a read/write flag. The block compares the address with a table of inclusive address windows, one window per parameter entry. For the matching window it raises a chip select and one register enable. The enable is a read enable or a write enable, chosen by the direction of the transfer.

All user-side strobes come from registers and stay high until the user logic returns a one-cycle acknowledge of the matching direction. One cycle after that acknowledge, the strobes are gone and a one-cycle completion pulse goes upstream, carrying the read data captured at the acknowledge. An address outside every window is never shown to the user logic. It completes on its own after a fixed number of cycles and returns zero. The upstream port must not issue a new request until the completion pulse of the previous one.

Top module: `sb_ce_decoder`

## Requirements
- R1: `cs_o` has one bit per window. Bit i is the only chip select high during a transfer whose address lies in window i (base to high, both inclusive). At most one chip select is ever high.
- R2: `rdce_o` and `wrce_o` are each as wide as the sum of the per-window enable counts. Window i owns a contiguous group of bits that starts at the sum of the counts of windows 0 to i-1. Inside that group, the bit chosen is ((address - base) >> log2(DATA_W/8)) modulo the window's count. At most one enable bit of either vector is high at a time.
- R3: `rnw_o` is 1 for a read and 0 for a write, and it is valid while any enable is high. A read raises the read enable in the same cycle as the chip select. A write raises the write enable together with the request data on `wdata_o`.
- R4: `be_o` is DATA_W/8 bits wide and equals the request byte enables from the first chip-select cycle on. `addr_o`, `wdata_o` and `be_o` do not change while the strobes stay high.
- R5: The strobes go high in the cycle after a request is accepted in idle. A request raised while a transfer is in progress is ignored.
- R6: When `rd_ack_i` is high with a read enable active, `user_rdata_i` is captured in that cycle. In the next cycle the chip select, read enable and `rnw_o` are low, `done_o` is high for exactly one cycle, and `rdata_o` carries the captured data.
- R7: When `wr_ack_i` is high with a write enable active, in the next cycle all strobes are low, `done_o` is high for one cycle, and `rdata_o` is 0.
- R8: An acknowledge that does not match the active direction has no effect. This covers a read acknowledge with no read enable active and a write acknowledge with no write enable active, including acknowledges that arrive while idle.
- R9: A request whose address lies in no window raises no strobe. `done_o` rises MISS_CYCLES clock edges after the accepting edge, with `rdata_o` equal to 0.
- R10: Asserting `rst_ni` low clears every strobe, `done_o` and `rdata_o` at once, without waiting for a clock edge, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request strobe |
| req_rnw_i | input | 1 | Request direction, 1 = read |
| req_addr_i | input | ADDR_W | Request byte address |
| req_wdata_i | input | DATA_W | Request write data |
| req_be_i | input | DATA_W/8 | Request byte enables |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with done_o |
| cs_o | output | NUM_RANGES | Per-window chip selects |
| rdce_o | output | TOTAL_CE | Register read enables |
| wrce_o | output | TOTAL_CE | Register write enables |
| rnw_o | output | 1 | User-side direction flag |
| addr_o | output | ADDR_W | User-side address |
| wdata_o | output | DATA_W | User-side write data |
| be_o | output | DATA_W/8 | User-side byte enables |
| rd_ack_i | input | 1 | User read acknowledge |
| wr_ack_i | input | 1 | User write acknowledge |
| user_rdata_i | input | DATA_W | User read data |

## Verification
The assertions check the invariants that hold in every cycle: chip selects are one-hot, enables are one-hot and never appear without a chip select, the enable direction agrees with `rnw_o`, and address, data and byte enables stay stable across a held transfer. They also check that a matching acknowledge drops every strobe and pulses completion one cycle later, and that completion never lasts two cycles. Only the bench scenarios show the things that depend on the address table and on timing. These are which window and which enable bit a given address selects, including the modulo wrap in a window with a non-power-of-two enable count, and the exact timeout of an unclaimed address. The bench scenarios also cover acknowledges of the wrong direction, requests raised while busy, and a reset in the middle of a transfer.

// File: rtl/sb_ce_pkg.sv
package sb_ce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_USER = 2'd1,
    ST_MISS = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sb_ce_addr_decode.sv
module sb_ce_addr_decode #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_RANGES = 3,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_BASE = {32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_HIGH = {32'h0000_20FF, 32'h0000_10FF, 32'h0000_00FF},
  parameter logic [NUM_RANGES-1:0][7:0]        RANGE_NCE  = {8'd3, 8'd8, 8'd4},
  parameter int TOTAL_CE   = 15
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_RANGES-1:0] cs_o,
  output logic [TOTAL_CE-1:0]   ce_o,
  output logic                  hit_o
);
  localparam int BYTE_SH = $clog2(DATA_W/8);

  function automatic int ce_base(input int r);
    int s = 0;
    for (int k = 0; k < r; k++) s += int'(RANGE_NCE[k]);
    return s;
  endfunction

  logic [NUM_RANGES-1:0] raw;

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_cmp
    assign raw[r] = (addr_i >= RANGE_BASE[r]) && (addr_i <= RANGE_HIGH[r]);
  end

  // lowest window index wins on overlap
  assign cs_o  = raw & ~(raw - NUM_RANGES'(1));
  assign hit_o = |raw;

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
    localparam int OFF = ce_base(r);
    localparam int NCE = int'(RANGE_NCE[r]);
    logic [ADDR_W-1:0] woff;
    logic [ADDR_W-1:0] idx;
    assign woff = (addr_i - RANGE_BASE[r]) >> BYTE_SH;
    assign idx  = woff % ADDR_W'(NCE);
    for (genvar j = 0; j < NCE; j++) begin : g_ce
      assign ce_o[OFF+j] = cs_o[r] && (idx == ADDR_W'(j));
    end
  end
endmodule

// File: rtl/sb_ce_xfer_ctl.sv
module sb_ce_xfer_ctl
  import sb_ce_pkg::*;
#(
  parameter int MISS_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic req_rnw_i,
  input  logic hit_i,
  input  logic rd_ack_i,
  input  logic wr_ack_i,
  output logic accept_o,
  output logic ack_ok_o,
  output logic rd_cap_o,
  output logic miss_end_o
);
  localparam int CNT_W = (MISS_CYCLES > 1) ? $clog2(MISS_CYCLES) : 1;

  sb_state_e        state_q;
  logic             rnw_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign ack_ok_o   = (state_q == ST_USER) && (rnw_q ? rd_ack_i : wr_ack_i);
  assign rd_cap_o   = ack_ok_o && rnw_q;
  assign miss_end_o = (state_q == ST_MISS) && (cnt_q == CNT_W'(MISS_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rnw_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          rnw_q   <= req_rnw_i;
          cnt_q   <= '0;
          state_q <= hit_i ? ST_USER : ST_MISS;
        end
        ST_USER: if (ack_ok_o) state_q <= ST_IDLE;
        ST_MISS: begin
          if (miss_end_o) state_q <= ST_IDLE;
          else            cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_ce_decoder.sv
module sb_ce_decoder #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_RANGES  = 3,
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_BASE = {32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [NUM_RANGES-1:0][ADDR_W-1:0] RANGE_HIGH = {32'h0000_20FF, 32'h0000_10FF, 32'h0000_00FF},
  parameter logic [NUM_RANGES-1:0][7:0]        RANGE_NCE  = {8'd3, 8'd8, 8'd4},
  parameter int MISS_CYCLES = 4,
  localparam int BE_W       = DATA_W / 8,
  localparam int TOTAL_CE   = sum_ce()
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  req_rnw_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic [BE_W-1:0]       req_be_i,
  output logic                  done_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_RANGES-1:0] cs_o,
  output logic [TOTAL_CE-1:0]   rdce_o,
  output logic [TOTAL_CE-1:0]   wrce_o,
  output logic                  rnw_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_W-1:0]     wdata_o,
  output logic [BE_W-1:0]       be_o,
  input  logic                  rd_ack_i,
  input  logic                  wr_ack_i,
  input  logic [DATA_W-1:0]     user_rdata_i
);
  function automatic int sum_ce();
    int s = 0;
    for (int k = 0; k < NUM_RANGES; k++) s += int'(RANGE_NCE[k]);
    return s;
  endfunction

  logic [NUM_RANGES-1:0] dec_cs;
  logic [TOTAL_CE-1:0]   dec_ce;
  logic                  dec_hit;
  logic                  accept, ack_ok, rd_cap, miss_end;

  sb_ce_addr_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_RANGES(NUM_RANGES),
    .RANGE_BASE(RANGE_BASE),
    .RANGE_HIGH(RANGE_HIGH),
    .RANGE_NCE (RANGE_NCE),
    .TOTAL_CE  (TOTAL_CE)
  ) u_dec (
    .addr_i(req_addr_i),
    .cs_o  (dec_cs),
    .ce_o  (dec_ce),
    .hit_o (dec_hit)
  );

  sb_ce_xfer_ctl #(
    .MISS_CYCLES(MISS_CYCLES)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .req_rnw_i (req_rnw_i),
    .hit_i     (dec_hit),
    .rd_ack_i  (rd_ack_i),
    .wr_ack_i  (wr_ack_i),
    .accept_o  (accept),
    .ack_ok_o  (ack_ok),
    .rd_cap_o  (rd_cap),
    .miss_end_o(miss_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o    <= '0;
      rdce_o  <= '0;
      wrce_o  <= '0;
      rnw_o   <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      be_o    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= ack_ok | miss_end;
      if (accept) begin
        addr_o  <= req_addr_i;
        wdata_o <= req_wdata_i;
        be_o    <= req_be_i;
        if (dec_hit) begin
          cs_o   <= dec_cs;
          rdce_o <= req_rnw_i ? dec_ce : '0;
          wrce_o <= req_rnw_i ? '0 : dec_ce;
          rnw_o  <= req_rnw_i;
        end
      end else if (ack_ok) begin
        cs_o   <= '0;
        rdce_o <= '0;
        wrce_o <= '0;
        rnw_o  <= 1'b0;
      end
      if (rd_cap)                rdata_o <= user_rdata_i;
      else if (ack_ok | miss_end) rdata_o <= '0;
    end
  end
endmodule

// File: rtl/sb_ce_decoder_chk.sv
module sb_ce_decoder_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_RANGES = 3,
  parameter int TOTAL_CE   = 15
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_RANGES-1:0] cs_o,
  input logic [TOTAL_CE-1:0]   rdce_o,
  input logic [TOTAL_CE-1:0]   wrce_o,
  input logic                  rnw_o,
  input logic [ADDR_W-1:0]     addr_o,
  input logic [DATA_W-1:0]     wdata_o,
  input logic [DATA_W/8-1:0]   be_o,
  input logic                  rd_ack_i,
  input logic                  wr_ack_i,
  input logic                  done_o
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o)); // R1

  AST_CE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rdce_o, wrce_o})); // R2

  AST_CE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{rdce_o, wrce_o}) |-> (|cs_o)); // R2

  AST_RD_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rdce_o) |-> rnw_o); // R3

  AST_WR_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrce_o) |-> !rnw_o); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|cs_o) && $past(|cs_o)) |-> ($stable(addr_o) && $stable(be_o) && $stable(wdata_o))); // R4

  AST_RD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rdce_o) && rd_ack_i) |=> (cs_o == '0 && rdce_o == '0 && !rnw_o && done_o)); // R6

  AST_WR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|wrce_o) && wr_ack_i) |=> (cs_o == '0 && wrce_o == '0 && done_o)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
endmodule

bind sb_ce_decoder sb_ce_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_RANGES(NUM_RANGES),
  .TOTAL_CE  (TOTAL_CE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_o    (cs_o),
  .rdce_o  (rdce_o),
  .wrce_o  (wrce_o),
  .rnw_o   (rnw_o),
  .addr_o  (addr_o),
  .wdata_o (wdata_o),
  .be_o    (be_o),
  .rd_ack_i(rd_ack_i),
  .wr_ack_i(wr_ack_i),
  .done_o  (done_o)
);

// File: tb/sb_ce_decoder_test.sv
`timescale 1ns/1ps
module sb_ce_decoder_test;
  localparam int NR = 3;
  localparam int NCE = 15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_rnw_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [3:0]  req_be_i = '0;
  logic        done_o;
  logic [31:0] rdata_o;
  logic [NR-1:0]  cs_o;
  logic [NCE-1:0] rdce_o, wrce_o;
  logic        rnw_o;
  logic [31:0] addr_o, wdata_o;
  logic [3:0]  be_o;
  logic        rd_ack_i = 1'b0, wr_ack_i = 1'b0;
  logic [31:0] user_rdata_i = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sb_ce_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_rnw_i(req_rnw_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .done_o(done_o), .rdata_o(rdata_o), .cs_o(cs_o), .rdce_o(rdce_o),
    .wrce_o(wrce_o), .rnw_o(rnw_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .be_o(be_o), .rd_ack_i(rd_ack_i), .wr_ack_i(wr_ack_i),
    .user_rdata_i(user_rdata_i)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // windows: 0x0000-0x00FF (4 enables, bits 0..3), 0x1000-0x10FF (8, bits 4..11),
  // 0x2000-0x20FF (3, bits 12..14)
  function automatic logic [NR-1:0] exp_cs(input logic [31:0] a);
    if (a <= 32'h00FF)                      return 3'b001;
    if (a >= 32'h1000 && a <= 32'h10FF)     return 3'b010;
    if (a >= 32'h2000 && a <= 32'h20FF)     return 3'b100;
    return 3'b000;
  endfunction

  function automatic logic [NCE-1:0] exp_ce(input logic [31:0] a);
    logic [NCE-1:0] v = '0;
    if (a <= 32'h00FF)                      v[(a >> 2) % 4] = 1'b1;
    else if (a >= 32'h1000 && a <= 32'h10FF) v[4 + ((a - 32'h1000) >> 2) % 8] = 1'b1;
    else if (a >= 32'h2000 && a <= 32'h20FF) v[12 + ((a - 32'h2000) >> 2) % 3] = 1'b1;
    return v;
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 reset cs",    64'(cs_o), 0);
    chk("R10 reset ce",    64'({rdce_o, wrce_o}), 0);
    chk("R10 reset done",  64'(done_o), 0);
    chk("R10 reset rdata", 64'(rdata_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // wrong: pulse the opposite-direction ack in first hold cycle; busy: new request then
  task automatic t_user(input bit rnw, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input int delay, input logic [31:0] rd,
                        input bit wrong, input bit busy);
    logic [NCE-1:0] ce = exp_ce(a);
    req_i = 1'b1; req_rnw_i = rnw; req_addr_i = a; req_wdata_i = wd; req_be_i = be;
    @(negedge clk);
    req_i = 1'b0; req_addr_i = '0; req_wdata_i = '0; req_be_i = '0;
    chk("R1 cs select",   64'(cs_o), 64'(exp_cs(a)));
    chk("R2 rd enable",   64'(rdce_o), rnw ? 64'(ce) : 0);
    chk("R2 wr enable",   64'(wrce_o), rnw ? 0 : 64'(ce));
    chk("R3 rnw flag",    64'(rnw_o), 64'(rnw));
    chk("R4 be",          64'(be_o), 64'(be));
    chk("R4 addr",        64'(addr_o), 64'(a));
    if (!rnw) chk("R3 wdata with wrce", 64'(wdata_o), 64'(wd));
    for (int k = 0; k < delay; k++) begin
      if (k == 0 && wrong) begin
        if (rnw) wr_ack_i = 1'b1; else rd_ack_i = 1'b1;
      end
      if (k == 0 && busy) begin
        req_i = 1'b1; req_rnw_i = ~rnw; req_addr_i = 32'h1008; req_be_i = 4'h3;
      end
      @(negedge clk);
      rd_ack_i = 1'b0; wr_ack_i = 1'b0; req_i = 1'b0; req_addr_i = '0; req_be_i = '0;
      chk("R8 held cs",     64'(cs_o), 64'(exp_cs(a)));
      chk("R8 held ce",     64'({rdce_o, wrce_o}), rnw ? 64'({ce, 15'd0}) : 64'(ce));
      chk("R8 no done",     64'(done_o), 0);
      if (busy) chk("R5 busy req ignored addr", 64'(addr_o), 64'(a));
      if (busy) chk("R5 busy req ignored be",   64'(be_o), 64'(be));
    end
    if (rnw) begin rd_ack_i = 1'b1; user_rdata_i = rd; end
    else wr_ack_i = 1'b1;
    @(negedge clk);
    rd_ack_i = 1'b0; wr_ack_i = 1'b0; user_rdata_i = 32'hDEAD_0000;
    chk(rnw ? "R6 done" : "R7 done",     64'(done_o), 1);
    chk(rnw ? "R6 rdata" : "R7 rdata",   64'(rdata_o), rnw ? 64'(rd) : 0);
    chk(rnw ? "R6 cs off" : "R7 cs off", 64'(cs_o), 0);
    chk(rnw ? "R6 ce off" : "R7 ce off", 64'({rdce_o, wrce_o}), 0);
    if (rnw) chk("R6 rnw off", 64'(rnw_o), 0);
    @(negedge clk);
    chk("R6 done one cycle", 64'(done_o), 0);
  endtask

  task automatic t_miss(input bit rnw, input logic [31:0] a);
    req_i = 1'b1; req_rnw_i = rnw; req_addr_i = a; req_be_i = 4'hF;
    user_rdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    req_i = 1'b0; req_addr_i = '0; req_be_i = '0;
    for (int k = 0; k < 4; k++) begin
      chk("R9 miss no cs",   64'(cs_o), 0);
      chk("R9 miss no ce",   64'({rdce_o, wrce_o}), 0);
      chk("R9 miss early",   64'(done_o), 0);
      if (k == 1) rd_ack_i = 1'b1;
      @(negedge clk);
      rd_ack_i = 1'b0;
    end
    chk("R9 miss done",  64'(done_o), 1);
    chk("R9 miss rdata", 64'(rdata_o), 0);
    @(negedge clk);
    chk("R9 miss done once", 64'(done_o), 0);
  endtask

  task automatic t_stray_idle();
    rd_ack_i = 1'b1; wr_ack_i = 1'b1;
    @(negedge clk);
    rd_ack_i = 1'b0; wr_ack_i = 1'b0;
    @(negedge clk);
    chk("R8 idle ack no done",  64'(done_o), 0);
    chk("R8 idle ack no cs",    64'(cs_o), 0);
    chk("R8 idle ack no rdata", 64'(rdata_o), 0);
  endtask

  task automatic t_mid_reset();
    req_i = 1'b1; req_rnw_i = 1'b1; req_addr_i = 32'h1020; req_be_i = 4'hF;
    @(negedge clk);
    req_i = 1'b0;
    chk("R1 pre-reset cs", 64'(cs_o), 3'b010);
    rst_ni = 1'b0;
    #1;
    chk("R10 async clear cs", 64'(cs_o), 0);
    chk("R10 async clear ce", 64'({rdce_o, wrce_o}), 0);
    chk("R10 async clear rnw", 64'(rnw_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    rd_ack_i = 1'b1; user_rdata_i = 32'h1234_5678;
    @(negedge clk);
    rd_ack_i = 1'b0;
    @(negedge clk);
    chk("R10 idle after reset", 64'(done_o), 0);
  endtask

  initial begin
    t_reset();
    t_user(1'b1, 32'h0000_000C, '0,            4'hF, 2, 32'hCAFE_0001, 1'b0, 1'b0);
    t_user(1'b0, 32'h0000_1014, 32'hA5A5_1234, 4'h6, 1, '0,            1'b0, 1'b0);
    t_user(1'b1, 32'h0000_2010, '0,            4'h1, 0, 32'h0BAD_F00D, 1'b0, 1'b0);
    t_user(1'b0, 32'h0000_2008, 32'h0000_00FF, 4'h8, 3, '0,            1'b1, 1'b0);
    t_user(1'b1, 32'h0000_10FC, '0,            4'hC, 2, 32'h7777_8888, 1'b1, 1'b1);
    t_user(1'b1, 32'h0000_00FF, '0,            4'h8, 1, 32'h1111_2222, 1'b0, 1'b0);
    t_user(1'b0, 32'h0000_20FC, 32'h3C3C_3C3C, 4'hF, 2, '0,            1'b0, 1'b1);
    t_miss(1'b1, 32'h0000_0500);
    t_miss(1'b0, 32'h0000_3000);
    t_stray_idle();
    t_mid_reset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule